// File: doc/BRIEF.md
# Overcurrent Fault Integrator

This block filters the output of an analog overcurrent comparator before it becomes a protection fault. On every sample tick, one per fixed interval, it reads the comparator. A reading of "over" moves an up/down counter up by one and a reading of "under" moves it down by one. When the counter reaches its limit, a fault is latched. A brief overload therefore wears off, and a sustained overload trips after a bounded number of samples. With the defaults (200 MHz clock, 3000 cycles per sample, limit of eight) this bound is about 120 µs.

A second comparator, set well above the normal threshold, detects hard shorts. Its output is qualified over a short run of consecutive cycles and then latches the fault at once, whatever the counter holds. The filter length must fit inside a deadline parameter, which by default is 2 µs.

Protection starts out disarmed and stays disarmed until a re-arm pulse arrives. That pulse shows the sense voltage has dropped back below the set point. A controller FSM has three states:

- DISARMED: entered from reset, or from any state while the enable input is low.
- ARMED: entered from DISARMED by the transition *arm*, which happens when enable and re-arm are both high.
- TRIPPED: entered from ARMED by the transition *trip_count*, when the counter reaches its limit, or by the transition *trip_short*, when the hard-short input is qualified.

TRIPPED is left only through reset or the transition *disable*, which fires when enable goes low.

Top module: `ocp_fault_integrator`

## Requirements
- R1: After reset, `fault` is 0 and `dbg_count` is 0.
- R2: Until a re-arm pulse is seen with `en` high, `oc_over` and `hs_short` have no effect: `dbg_count` stays 0 and `fault` stays 0.
- R3: Once armed, the counter changes only on sample ticks. The first tick falls SAMPLE_DIV cycles after the arming edge, and each later tick follows the previous one by SAMPLE_DIV cycles. The level of `oc_over` between ticks has no effect.
- R4: On a tick, `dbg_count` rises by 1 if `oc_over` is 1 and falls by 1 if `oc_over` is 0.
- R5: A decrement from 0 leaves `dbg_count` at 0, and the count never exceeds COUNT_LIMIT.
- R6: `fault` becomes 1 on the same edge on which `dbg_count` reaches COUNT_LIMIT. Starting from 0, COUNT_LIMIT consecutive over samples give the fastest trip, and COUNT_LIMIT-1 such samples do not trip.
- R7: While armed, if `hs_short` is 1 for HS_FILT consecutive clock edges, `fault` is set on the last of those edges, whatever the count is. A shorter run does not set it. HS_FILT must be smaller than HS_DEADLINE.
- R8: Once set, `fault` stays 1 and `dbg_count` stays frozen for as long as `en` remains high.
- R9: `en` low clears `fault` and `dbg_count` at the next edge and returns the block to the disarmed state. A new re-arm pulse is then needed before protection resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low disarms the block and clears a latched fault |
| oc_over | input | 1 | Normal overcurrent comparator, 1 = above threshold |
| hs_short | input | 1 | Hard-short comparator, 1 = far above threshold |
| rearm | input | 1 | Start-up re-arm indication |
| fault | output | 1 | Latched overcurrent fault |
| dbg_count | output | $clog2(COUNT_LIMIT+1) | Current integrator count |

## Verification
The hardest situation to reach from the ports is the tick boundary. The counter must stay put while `oc_over` is high for an entire window that ends just before a tick, and must then ignore that window when the tick samples a low level. The bench reaches this boundary by counting cycles from the arming edge, holding `oc_over` high for SAMPLE_DIV-1 cycles and dropping it on the tick edge. From that point it keeps the tick phase exact, so that the vector table, whose windows are multiples of the sample period, lands each check just after a tick. It also places a hard-short run one cycle shorter than the filter directly before a full run, which shows that the filter restarts.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_TRIPPED  = 2'd2
    } ocp_state_t;
endpackage

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
    parameter int SAMPLE_DIV = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(SAMPLE_DIV + 1);
    localparam logic [TW-1:0] LAST = TW'(SAMPLE_DIV - 1);

    logic [TW-1:0] div_q;

    assign tick = run && (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    generate
        if (SAMPLE_DIV > 1) begin : g_spacing
            // R3: ticks are isolated pulses
            assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ocp_hs_filter.sv
module ocp_hs_filter #(
    parameter int HS_FILT     = 40,
    parameter int HS_DEADLINE = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hs_in,
    output logic qual
);
    localparam int HW = $clog2(HS_FILT + 1);
    localparam logic [HW-1:0] HLAST = HW'(HS_FILT - 1);

    logic [HW-1:0] run_q;

    generate
        if (HS_FILT < 1 || HS_FILT >= HS_DEADLINE) begin : g_bad_filter
            $error("hard-short filter length must be positive and below the deadline");
        end
    endgenerate

    assign qual = run && hs_in && (run_q == HLAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!run || !hs_in) begin
            run_q <= '0;
        end else if (run_q != HLAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R7: qualification never asserts without the short input present
    assert_hs_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> hs_in);
endmodule

// File: rtl/ocp_leaky_count.sv
module ocp_leaky_count #(
    parameter int COUNT_LIMIT = 8,
    parameter int CW = $clog2(COUNT_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          up,
    output logic [CW-1:0] cnt,
    output logic          reach
);
    localparam logic [CW-1:0] LIM = CW'(COUNT_LIMIT);

    assign reach = step && up && (cnt == LIM - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            if (up) begin
                if (cnt != LIM) cnt <= cnt + 1'b1;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R5: never beyond the limit
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
    // R3: no movement without a sample step
    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/ocp_fault_integrator.sv
module ocp_fault_integrator
    import ocp_pkg::*;
#(
    parameter int SAMPLE_DIV  = 3000,
    parameter int COUNT_LIMIT = 8,
    parameter int HS_FILT     = 40,
    parameter int HS_DEADLINE = 400,
    localparam int CW = $clog2(COUNT_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          oc_over,
    input  logic          hs_short,
    input  logic          rearm,
    output logic          fault,
    output logic [CW-1:0] dbg_count
);
    ocp_state_t state_q, state_d;
    logic armed, tick, hs_qual, reach;
    logic [CW-1:0] cnt;

    assign armed = (state_q == ST_ARMED);

    ocp_tick_gen #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(armed), .tick(tick)
    );

    ocp_hs_filter #(.HS_FILT(HS_FILT), .HS_DEADLINE(HS_DEADLINE)) u_hs (
        .clk(clk), .rst_n(rst_n), .run(armed), .hs_in(hs_short), .qual(hs_qual)
    );

    ocp_leaky_count #(.COUNT_LIMIT(COUNT_LIMIT), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!en), .step(armed && tick),
        .up(oc_over), .cnt(cnt), .reach(reach)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_DISARMED;                       // disable
        end else begin
            unique case (state_q)
                ST_DISARMED: if (rearm) state_d = ST_ARMED;            // arm
                ST_ARMED:    if (reach || hs_qual) state_d = ST_TRIPPED; // trip_count / trip_short
                ST_TRIPPED:  state_d = ST_TRIPPED;
                default:     state_d = ST_DISARMED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fault     = (state_q == ST_TRIPPED);
        dbg_count = cnt;
    end

    // R2: nothing accumulates while disarmed
    assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISARMED) |-> (dbg_count == '0 && !fault));
    // R6: a full count always shows a fault
    assert_trip_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_count == CW'(COUNT_LIMIT)) |-> fault);
    // R8: fault latched and count frozen while enabled
    assert_fault_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && en) |=> fault);
    assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && en) |=> $stable(dbg_count));
    // R9: enable low clears everything
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!fault && dbg_count == '0));
endmodule

// File: tb/ocp_fault_integrator_bench.sv
module ocp_fault_integrator_bench;
    localparam int SDIV = 16;
    localparam int LIM  = 8;
    localparam int HSF  = 4;
    localparam int CW   = $clog2(LIM + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, oc_over = 1'b0, hs_short = 1'b0, rearm = 1'b0;
    logic fault;
    logic [CW-1:0] dbg_count;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ocp_fault_integrator #(.SAMPLE_DIV(SDIV), .COUNT_LIMIT(LIM), .HS_FILT(HSF), .HS_DEADLINE(400))
    u_ocp_fault_integrator (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_over(oc_over), .hs_short(hs_short),
        .rearm(rearm), .fault(fault), .dbg_count(dbg_count)
    );

    typedef struct packed {
        logic       oc;
        logic [3:0] ticks;
        logic [3:0] cnt;
        logic       flt;
    } vec_t;

    // R4 / R5 / R6 / R8 walk, continuing from count 0 at a tick boundary
    localparam vec_t VECS [8] = '{
        '{1'b1, 4'd3, 4'd3, 1'b0},   // R4 up
        '{1'b0, 4'd1, 4'd2, 1'b0},   // R4 down
        '{1'b0, 4'd4, 4'd0, 1'b0},   // R5 floor at zero
        '{1'b1, 4'd2, 4'd2, 1'b0},
        '{1'b0, 4'd1, 4'd1, 1'b0},
        '{1'b1, 4'd6, 4'd7, 1'b0},   // R6 one short
        '{1'b1, 4'd1, 4'd8, 1'b1},   // R6 trip
        '{1'b0, 4'd3, 4'd8, 1'b1}    // R8 frozen
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic arm();
        en = 1'b1; rearm = 1'b1;
        step(1);
        rearm = 1'b0;
    endtask

    initial begin
        step(3);
        chk("R1 fault", fault, 0);
        chk("R1 count", dbg_count, 0);
        rst_n = 1'b1;
        step(1);

        // R2: inputs ignored without re-arm
        en = 1'b1; oc_over = 1'b1; hs_short = 1'b1;
        step(3 * SDIV);
        chk("R2 fault", fault, 0);
        chk("R2 count", dbg_count, 0);
        oc_over = 1'b0; hs_short = 1'b0;

        // R3: over level between ticks is not sampled
        arm();
        oc_over = 1'b1;
        step(SDIV - 1);
        chk("R3 mid-window count", dbg_count, 0);
        oc_over = 1'b0;
        step(1);
        chk("R3 tick samples low", dbg_count, 0);

        for (int i = 0; i < 8; i++) begin
            oc_over = VECS[i].oc;
            step(int'(VECS[i].ticks) * SDIV);
            chk("R4/R5/R6/R8 vector count", dbg_count, int'(VECS[i].cnt));
            chk("R4/R5/R6/R8 vector fault", fault, int'(VECS[i].flt));
        end
        oc_over = 1'b0;

        // R9: disable clears, then needs re-arm
        en = 1'b0;
        step(1);
        chk("R9 fault cleared", fault, 0);
        chk("R9 count cleared", dbg_count, 0);
        en = 1'b1; oc_over = 1'b1;
        step(3 * SDIV);
        chk("R9 no re-arm count", dbg_count, 0);
        chk("R9 no re-arm fault", fault, 0);
        oc_over = 1'b0;

        // R7: short run rejected, full run trips
        arm();
        hs_short = 1'b1;
        step(HSF - 1);
        hs_short = 1'b0;
        step(1);
        chk("R7 short run no trip", fault, 0);
        hs_short = 1'b1;
        step(HSF - 1);
        chk("R7 before last edge", fault, 0);
        step(1);
        chk("R7 trip on last edge", fault, 1);
        chk("R7 count untouched", dbg_count, 0);
        hs_short = 1'b0;

        // R1: reset clears a latched fault
        rst_n = 1'b0;
        step(1);
        chk("R1 reset clears fault", fault, 0);
        rst_n = 1'b1;
        step(1);

        // R6: fastest normal trip
        arm();
        oc_over = 1'b1;
        step((LIM - 1) * SDIV);
        chk("R6 limit-1 no fault", fault, 0);
        chk("R6 limit-1 count", dbg_count, LIM - 1);
        step(SDIV);
        chk("R6 fastest trip fault", fault, 1);
        chk("R6 fastest trip count", dbg_count, LIM);
        oc_over = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule